// File: doc/BRIEF.md
# Passive Two-Wire Bus Observer

This block watches an I2C bus and reports everything it sees. It has no output toward the bus wires, so it can neither stretch the clock nor acknowledge a byte. It decodes every transfer whatever the target address. It turns the bus activity into a stream of event records on a valid/ready interface. A capture memory or a host sits downstream. Every START condition also raises a single-cycle trigger strobe, which can arm a scope or a logic analyser.

Both bus lines pass through a two-stage synchroniser and a glitch filter before any edge is decoded. The filter accepts a new level only after it has been stable for `FILT_LEN` clock cycles. Each record carries the following:
- an event kind;
- the byte value;
- the acknowledge seen on the ninth clock;
- a flag for a general-call first byte;
- a flag for a 10-bit address header;
- an extracted address, when the byte pattern supplies one.

The output register holds one record. If the consumer is still stalled when the next record completes, the new record is discarded and a sticky overflow flag is raised.

Top module: `i2c_bus_monitor`

## Requirements
- R1: The block has no output that reaches SCL or SDA, so it never acknowledges. A byte that no other device acknowledges is reported with an ack field of 0.
- R2: `trig_o` pulses high for exactly one clock on every START, both the first START and a repeated START. It never pulses for a STOP or a data bit.
- R3: SDA falling while SCL is high is a START. It is reported as kind 0 when the bus was idle and as kind 1 (repeated START) inside a transfer. SDA rising while SCL is high inside a transfer is reported as kind 2 (STOP).
- R4: Data bits are taken on SCL rising edges, most significant bit first. After the ninth rising edge a record of kind 3 carries the 8 bits in `rec_data_o`.
- R5: On a kind-3 record, `rec_ack_o` is 1 when SDA was low at the ninth rising edge and 0 when SDA was high. Records of kinds 0 to 2 carry zero data, a zero ack field and no flags.
- R6: The first byte after a START or repeated START that equals 0x00 sets `rec_gcall_o`. The byte after it, if its bit 0 is 1, sets `rec_addr_vld_o` with `rec_addr_o` = {3'b000, byte[7:1]}. A 0x00 byte in any later position is not flagged.
- R7: A first byte whose bits [7:3] are 11110 sets `rec_hdr10_o`. The byte after it sets `rec_addr_vld_o` with `rec_addr_o` = {header[2:1], byte}.
- R8: A STOP in the middle of a byte discards the partial byte and yields only the STOP record. The next transfer decodes normally.
- R9: While `rec_valid_o` is high and `rec_ready_i` is low, the record stays stable. A record that completes in that state is dropped and sets `overflow_o`. `overflow_o` stays set until reset.
- R10: A level change on either line that lasts fewer than `FILT_LEN` clock cycles causes no trigger and no record.
- R11: After reset, `rec_valid_o`, `trig_o` and `overflow_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, sensed only |
| sda_i | input | 1 | Bus data line, sensed only |
| trig_o | output | 1 | One-cycle strobe on each START |
| rec_valid_o | output | 1 | Record available |
| rec_ready_i | input | 1 | Consumer accepts record |
| rec_kind_o | output | 2 | 0 START, 1 repeated START, 2 STOP, 3 byte |
| rec_data_o | output | 8 | Byte value |
| rec_ack_o | output | 1 | 1 when the ninth bit was low |
| rec_gcall_o | output | 1 | First byte was the general-call value |
| rec_hdr10_o | output | 1 | First byte is a 10-bit address header |
| rec_addr_vld_o | output | 1 | `rec_addr_o` holds a decoded address |
| rec_addr_o | output | 10 | Sender address or full 10-bit address |
| overflow_o | output | 1 | Sticky: a record was dropped |

## Verification
A bit counter that slips shows up within one byte. The next kind-3 record carries a shifted value or a wrong ack, or a record appears at a START boundary where none belongs. If the in-transfer state is wrong, the very next START is reported as the wrong kind, or a STOP goes missing. A stale first-byte or pending-header flag shows on the following byte record, as a general-call or header flag in the wrong position or as a wrong decoded address. A broken filter shows within a few cycles as a spurious trigger after a short pulse.

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor #(
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       trig_o,
  output logic       rec_valid_o,
  input  logic       rec_ready_i,
  output logic [1:0] rec_kind_o,
  output logic [7:0] rec_data_o,
  output logic       rec_ack_o,
  output logic       rec_gcall_o,
  output logic       rec_hdr10_o,
  output logic       rec_addr_vld_o,
  output logic [9:0] rec_addr_o,
  output logic       overflow_o
);
  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_LEN - 1);
  localparam logic [1:0] K_START = 2'd0, K_RESTART = 2'd1, K_STOP = 2'd2, K_BYTE = 2'd3;

  logic [1:0] s1, s2, flt, prv;
  logic [CNT_W-1:0] cnt [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; flt <= 2'b11; prv <= 2'b11;
      cnt[0] <= '0; cnt[1] <= '0;
    end else begin
      s1  <= {scl_i, sda_i};
      s2  <= s1;
      prv <= flt;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] == flt[i]) cnt[i] <= '0;
        else if (cnt[i] == CNT_MAX) begin
          flt[i] <= s2[i];
          cnt[i] <= '0;
        end else cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  wire f_scl = flt[1], f_sda = flt[0], p_scl = prv[1], p_sda = prv[0];
  wire cond_start = f_scl & p_scl & p_sda & ~f_sda;
  wire cond_stop  = f_scl & p_scl & ~p_sda & f_sda;
  wire scl_rise   = f_scl & ~p_scl;

  logic       busy, first, gc_pend, h10_pend;
  logic [1:0] hdr_hi;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  wire byte_done = busy & scl_rise & (bitcnt == 4'd8);
  wire is_zero   = (shreg == 8'h00);
  wire is_hdr    = (shreg[7:3] == 5'b11110);

  logic       ev, ev_ack, ev_gc, ev_h10, ev_av;
  logic [1:0] ev_kind;
  logic [7:0] ev_data;
  logic [9:0] ev_addr;

  always_comb begin
    ev = 1'b0; ev_kind = K_BYTE; ev_data = '0; ev_ack = 1'b0;
    ev_gc = 1'b0; ev_h10 = 1'b0; ev_av = 1'b0; ev_addr = '0;
    if (cond_start) begin
      ev = 1'b1;
      ev_kind = busy ? K_RESTART : K_START;
    end else if (cond_stop && busy) begin
      ev = 1'b1;
      ev_kind = K_STOP;
    end else if (byte_done) begin
      ev = 1'b1;
      ev_data = shreg;
      ev_ack = ~f_sda;
      ev_gc = first & is_zero;
      ev_h10 = first & is_hdr;
      if (!first && gc_pend && shreg[0]) begin
        ev_av = 1'b1;
        ev_addr = {3'b000, shreg[7:1]};
      end else if (!first && h10_pend) begin
        ev_av = 1'b1;
        ev_addr = {hdr_hi, shreg};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; first <= 1'b0; gc_pend <= 1'b0; h10_pend <= 1'b0;
      hdr_hi <= '0; bitcnt <= '0; shreg <= '0;
    end else if (cond_start) begin
      busy <= 1'b1; first <= 1'b1; gc_pend <= 1'b0; h10_pend <= 1'b0;
      bitcnt <= '0;
    end else if (cond_stop) begin
      busy <= 1'b0; bitcnt <= '0;
    end else if (busy && scl_rise) begin
      if (bitcnt == 4'd8) begin
        bitcnt   <= '0;
        first    <= 1'b0;
        gc_pend  <= first & is_zero;
        h10_pend <= first & is_hdr;
        hdr_hi   <= shreg[2:1];
      end else begin
        shreg  <= {shreg[6:0], f_sda};
        bitcnt <= bitcnt + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_o <= 1'b0; rec_valid_o <= 1'b0; overflow_o <= 1'b0;
      rec_kind_o <= '0; rec_data_o <= '0; rec_ack_o <= 1'b0; rec_gcall_o <= 1'b0;
      rec_hdr10_o <= 1'b0; rec_addr_vld_o <= 1'b0; rec_addr_o <= '0;
    end else begin
      trig_o <= cond_start;
      if (rec_valid_o && rec_ready_i) rec_valid_o <= 1'b0;
      if (ev) begin
        if (!rec_valid_o || rec_ready_i) begin
          rec_valid_o    <= 1'b1;
          rec_kind_o     <= ev_kind;
          rec_data_o     <= ev_data;
          rec_ack_o      <= ev_ack;
          rec_gcall_o    <= ev_gc;
          rec_hdr10_o    <= ev_h10;
          rec_addr_vld_o <= ev_av;
          rec_addr_o     <= ev_addr;
        end else overflow_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_monitor_chk.sv
module i2c_bus_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trig_o,
  input logic       rec_valid_o,
  input logic       rec_ready_i,
  input logic [1:0] rec_kind_o,
  input logic [7:0] rec_data_o,
  input logic       rec_ack_o,
  input logic       rec_gcall_o,
  input logic       rec_hdr10_o,
  input logic       rec_addr_vld_o,
  input logic [9:0] rec_addr_o,
  input logic       overflow_o
);
  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) trig_o |=> !trig_o); // R2
  AST_TRIG_HAS_REC: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> ((rec_valid_o && rec_kind_o <= 2'd1) || overflow_o)); // R3
  AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_kind_o) && $stable(rec_data_o)
      && $stable(rec_addr_o))); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow_o |=> overflow_o); // R9
  AST_GCALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && rec_gcall_o) |-> (rec_kind_o == 2'd3 && rec_data_o == 8'h00)); // R6
  AST_HDR10_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && rec_hdr10_o) |-> (rec_kind_o == 2'd3 && rec_data_o[7:3] == 5'b11110)); // R7
  AST_ADDR_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && rec_addr_vld_o) |-> (rec_kind_o == 2'd3 && !rec_gcall_o && !rec_hdr10_o)); // R6
  AST_COND_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && rec_kind_o != 2'd3) |-> (rec_data_o == 8'h00 && !rec_ack_o && !rec_addr_vld_o)); // R5
endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .trig_o(trig_o), .rec_valid_o(rec_valid_o),
  .rec_ready_i(rec_ready_i), .rec_kind_o(rec_kind_o), .rec_data_o(rec_data_o),
  .rec_ack_o(rec_ack_o), .rec_gcall_o(rec_gcall_o), .rec_hdr10_o(rec_hdr10_o),
  .rec_addr_vld_o(rec_addr_vld_o), .rec_addr_o(rec_addr_o), .overflow_o(overflow_o)
);

// File: tb/i2c_bus_monitor_tb_top.sv
`timescale 1ns/1ps
module i2c_bus_monitor_tb_top;
  localparam int HB = 24;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1, rdy = 1'b1;
  logic trig, vld, ack, gc, h10, av, ovf;
  logic [1:0] kind;
  logic [7:0] data;
  logic [9:0] addr;
  int tests = 0, fails = 0, nrec = 0, ntrig = 0;
  logic [24:0] recs [64];

  always #4 clk = ~clk;

  i2c_bus_monitor #(.FILT_LEN(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .trig_o(trig),
    .rec_valid_o(vld), .rec_ready_i(rdy), .rec_kind_o(kind), .rec_data_o(data),
    .rec_ack_o(ack), .rec_gcall_o(gc), .rec_hdr10_o(h10), .rec_addr_vld_o(av),
    .rec_addr_o(addr), .overflow_o(ovf));

  always @(negedge clk) if (rst_n) begin
    if (trig) ntrig++;
    if (vld && rdy && nrec < 64) begin
      recs[nrec] = {kind, data, ack, gc, h10, av, addr};
      nrec++;
    end
  end

  task automatic hold(int n); repeat (n) @(posedge clk); #1; endtask

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic exp_rec(string req, int idx, logic [1:0] k, logic [7:0] d, logic a,
                         logic g, logic h, logic v, logic [9:0] ad);
    logic [24:0] e = {k, d, a, g, h, v, ad};
    chk(req, $sformatf("record %0d", idx), int'(recs[idx]), int'(e));
  endtask

  task automatic bus_start; sda = 1; scl = 1; hold(HB); sda = 0; hold(HB); scl = 0; hold(HB); endtask
  task automatic bus_restart; sda = 1; hold(HB); scl = 1; hold(HB); sda = 0; hold(HB); scl = 0; hold(HB); endtask
  task automatic bus_bit(logic b); sda = b; hold(HB); scl = 1; hold(HB); scl = 0; hold(HB); endtask
  task automatic bus_byte(logic [7:0] d, logic a);
    for (int i = 7; i >= 0; i--) bus_bit(d[i]);
    bus_bit(a);
  endtask
  task automatic bus_stop; sda = 0; hold(HB); scl = 1; hold(HB); sda = 1; hold(3*HB); endtask

  task automatic t_reset;
    rst_n = 0; hold(4);
    chk("R11", "valid at reset", vld, 0);
    chk("R11", "trig at reset", trig, 0);
    chk("R11", "overflow at reset", ovf, 0);
    rst_n = 1; hold(10);
  endtask

  task automatic t_write;
    int b = nrec, t = ntrig;
    bus_start; bus_byte(8'hA0, 0); bus_byte(8'h55, 0); bus_byte(8'h3C, 1); bus_stop;
    chk("R2", "write trig count", ntrig - t, 1);
    chk("R4", "write rec count", nrec - b, 5);
    exp_rec("R3", b, 2'd0, 8'h00, 0, 0, 0, 0, 0);
    exp_rec("R4", b + 1, 2'd3, 8'hA0, 1, 0, 0, 0, 0);
    exp_rec("R5", b + 2, 2'd3, 8'h55, 1, 0, 0, 0, 0);
    exp_rec("R1", b + 3, 2'd3, 8'h3C, 0, 0, 0, 0, 0);
    exp_rec("R3", b + 4, 2'd2, 8'h00, 0, 0, 0, 0, 0);
  endtask

  task automatic t_restart;
    int b = nrec, t = ntrig;
    bus_start; bus_byte(8'hA0, 0); bus_restart; bus_byte(8'hA1, 1); bus_stop;
    chk("R2", "restart trig count", ntrig - t, 2);
    chk("R3", "restart rec count", nrec - b, 5);
    exp_rec("R3", b + 2, 2'd1, 8'h00, 0, 0, 0, 0, 0);
    exp_rec("R5", b + 3, 2'd3, 8'hA1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_gcall;
    int b = nrec;
    bus_start; bus_byte(8'h00, 0); bus_byte(8'h35, 0); bus_byte(8'h00, 0); bus_stop;
    exp_rec("R6", b + 1, 2'd3, 8'h00, 1, 1, 0, 0, 0);
    exp_rec("R6", b + 2, 2'd3, 8'h35, 1, 0, 0, 1, 10'h01A);
    exp_rec("R6", b + 3, 2'd3, 8'h00, 1, 0, 0, 0, 0);
    b = nrec;
    bus_start; bus_byte(8'h00, 0); bus_byte(8'h34, 0); bus_stop;
    exp_rec("R6", b + 2, 2'd3, 8'h34, 1, 0, 0, 0, 0);
  endtask

  task automatic t_ten;
    int b = nrec;
    bus_start; bus_byte(8'hF4, 0); bus_byte(8'h5C, 0); bus_byte(8'hF4, 0); bus_stop;
    exp_rec("R7", b + 1, 2'd3, 8'hF4, 1, 0, 1, 0, 0);
    exp_rec("R7", b + 2, 2'd3, 8'h5C, 1, 0, 0, 1, 10'h25C);
    exp_rec("R7", b + 3, 2'd3, 8'hF4, 1, 0, 0, 0, 0);
  endtask

  task automatic t_partial;
    int b = nrec;
    bus_start; bus_bit(1); bus_bit(0); bus_bit(1); bus_bit(1); bus_stop;
    chk("R8", "partial rec count", nrec - b, 2);
    exp_rec("R8", b + 1, 2'd2, 8'h00, 0, 0, 0, 0, 0);
    b = nrec;
    bus_start; bus_byte(8'h00, 0); bus_stop;
    chk("R8", "after partial count", nrec - b, 3);
    exp_rec("R8", b + 1, 2'd3, 8'h00, 1, 1, 0, 0, 0);
  endtask

  task automatic t_glitch;
    int b = nrec, t = ntrig;
    sda = 0; hold(2); sda = 1; hold(30);
    scl = 0; hold(2); scl = 1; hold(30);
    chk("R10", "glitch trig", ntrig - t, 0);
    chk("R10", "glitch recs", nrec - b, 0);
  endtask

  task automatic t_overflow;
    int b = nrec;
    rdy = 0;
    bus_start; bus_byte(8'hA0, 0); bus_stop;
    chk("R9", "held valid", vld, 1);
    chk("R9", "held kind", kind, 0);
    chk("R9", "overflow set", ovf, 1);
    rdy = 1; hold(5);
    chk("R9", "one record survives", nrec - b, 1);
    chk("R9", "overflow sticky", ovf, 1);
    chk("R9", "valid cleared", vld, 0);
    rst_n = 0; hold(3);
    chk("R11", "overflow cleared", ovf, 0);
    rst_n = 1; hold(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    hold(1);
    t_reset;
    t_write;
    t_restart;
    t_gcall;
    t_ten;
    t_partial;
    t_glitch;
    t_overflow;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule